// File: doc/BRIEF.md
# Masked DAC Setpoint Packet Parser

This block sits behind a host byte link, such as a UART receiver, and turns programming packets into writes to a bank of DAC setpoint registers. Bytes arrive on a valid/data interface. A packet opens with a command byte. A channel-select mask follows, then a fixed table with one 14-bit setpoint for every channel. Only the channels that the mask selects are written. The values for the other channels are read off the link and thrown away.

As each selected channel's value completes, the parser raises a one-cycle write strobe that carries the channel index and the value. The setpoint register for that channel takes the value one cycle later. After the last byte of the table, a one-cycle done pulse is raised together with the captured mask, so a separate response sender can confirm the update. The number of channels is a parameter and may be 16, 24 or 32.

Top module: `dac_mask_loader`

## Requirements
- R1: While idle, only the byte 0x50 starts a packet. Any other byte is dropped, causes no strobe or done pulse, and leaves the setpoint registers unchanged.
- R2: The mask is the NUM_CH/8 bytes that follow the command byte: 4, 3 or 2 bytes for 32, 24 or 16 channels.
- R3: The mask is sent MSB first. Bit 7 of the first mask byte selects channel NUM_CH-1, and bit 0 of the last mask byte selects channel 0. A mask bit of 1 selects that channel for writing.
- R4: After the mask come two bytes per channel for every channel, in ascending order from channel 0. The write strobe carries the index of the channel whose bytes were just consumed.
- R5: A setpoint is built as {high byte bits 5:0, low byte bits 7:0}. Bits 7:6 of the high byte are ignored, and nonzero values there do not abort the packet.
- R6: `wr_stb` is high for exactly the one cycle after a selected channel's low byte is accepted. It stays low for unselected channels.
- R7: `done_stb` is high for one cycle, in the cycle after the last channel's low byte is accepted. At that time `done_mask` equals the captured mask, and the parser is idle again.
- R8: A setpoint register takes the strobed value in the cycle after its strobe. Registers that are not strobed keep their contents.
- R9: A synchronous reset returns the parser to idle and clears the mask and all setpoint registers to zero, including in the middle of a packet.
- R10: Bytes are consumed only in cycles where `in_valid` is high. Idle cycles inside a packet do not change its parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Input byte from the host link |
| wr_stb | output | 1 | One-cycle write strobe for a selected channel |
| wr_idx | output | $clog2(NUM_CH) | Channel index of the write |
| wr_val | output | 14 | Setpoint value of the write |
| done_stb | output | 1 | One-cycle end-of-packet pulse |
| done_mask | output | NUM_CH | Captured channel-select mask |
| ch_vals | output | NUM_CH*14 | All setpoint registers, channel c in bits [c*14 +: 14] |

## Verification
The assertions assume that `in_valid` and `in_byte` are driven to known values in every cycle once reset is released. They also assume that a strobe index always names an existing channel, which holds because the channel counter stops at NUM_CH-1. The stimulus changes its inputs one time unit after each rising edge and never leaves them undefined. It sends only whole packets or junk bytes while the parser is idle, except for one reset that is asserted deliberately in the middle of a packet. That keeps every strobe tied to a real channel and every done pulse separated from the next by a full packet length.

// File: rtl/dml_pkg.sv
package dml_pkg;
    localparam logic [7:0] CMD_BYTE = 8'h50;
    localparam int         SP_W     = 14;

    typedef logic [SP_W-1:0] setpt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MASK = 2'd1,
        ST_HI   = 2'd2,
        ST_LO   = 2'd3
    } pstate_t;

    function automatic int mask_len(input int nch);
        return nch / 8;
    endfunction

    function automatic setpt_t join_setpt(input logic [5:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/dml_sequencer.sv
module dml_sequencer
    import dml_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int MBYTES = mask_len(NUM_CH),
    localparam int MB_W = $clog2(MBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             mask_shift,
    output logic             hi_load,
    output logic             lo_take,
    output logic             last_ch,
    output logic [IDX_W-1:0] ch_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);
    localparam logic [MB_W-1:0]  LAST_MB  = MB_W'(MBYTES - 1);

    pstate_t          state;
    logic [MB_W-1:0]  mb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mb_cnt <= '0;
            ch_idx <= '0;
        end else if (in_valid) begin
            case (state)
                ST_IDLE: begin
                    if (in_byte == CMD_BYTE) begin
                        state  <= ST_MASK;
                        mb_cnt <= '0;
                    end
                end
                ST_MASK: begin
                    if (mb_cnt == LAST_MB) begin
                        state  <= ST_HI;
                        ch_idx <= '0;
                    end else begin
                        mb_cnt <= mb_cnt + 1'b1;
                    end
                end
                ST_HI: state <= ST_LO;
                ST_LO: begin
                    if (ch_idx == LAST_IDX) begin
                        state <= ST_IDLE;
                    end else begin
                        state  <= ST_HI;
                        ch_idx <= ch_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mask_shift = in_valid && (state == ST_MASK);
        hi_load    = in_valid && (state == ST_HI);
        lo_take    = in_valid && (state == ST_LO);
        last_ch    = (ch_idx == LAST_IDX);
    end

    // R1: a non-command byte while idle keeps the parser idle
    p_idle_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_valid && in_byte != CMD_BYTE) |=> (state == ST_IDLE));

    // R10: without a valid byte the parse position does not move
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(state) && $stable(ch_idx) && $stable(mb_cnt)));

    // R4: channels advance by one per low byte
    p_ch_step_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_take && !last_ch) |=> (ch_idx == $past(ch_idx) + 1'b1 && state == ST_HI));

    // R7: the last low byte returns the parser to idle
    p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (lo_take && last_ch) |=> (state == ST_IDLE));
endmodule

// File: rtl/dml_mask_reg.sv
module dml_mask_reg #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [7:0]        in_byte,
    output logic [NUM_CH-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (shift_en) begin
            mask_q <= {mask_q[NUM_CH-9:0], in_byte};
        end
    end

    // R9: reset clears the captured mask
    p_mask_clear_r9: assert property (@(posedge clk)
        rst |=> (mask_q == '0));

    // R3: the newest byte lands in the low bits (channels 7..0)
    p_mask_order_r3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (mask_q[7:0] == $past(in_byte)));
endmodule

// File: rtl/dml_word_asm.sv
module dml_word_asm
    import dml_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hi_load,
    input  logic             lo_take,
    input  logic             last_ch,
    input  logic             ch_sel,
    input  logic [IDX_W-1:0] ch_idx,
    input  logic [5:0]       hi_bits,
    input  logic [7:0]       lo_bits,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx,
    output setpt_t           wr_val,
    output logic             done_stb
);
    logic [5:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_val   <= '0;
            done_stb <= 1'b0;
        end else begin
            wr_stb   <= lo_take && ch_sel;
            done_stb <= lo_take && last_ch;
            if (hi_load) begin
                hi_q <= hi_bits;
            end
            if (lo_take) begin
                wr_idx <= ch_idx;
                wr_val <= join_setpt(hi_q, lo_bits);
            end
        end
    end

    // R7: the done pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_stb |=> !done_stb);

    // R6: a strobe needs a low byte on the previous edge
    p_stb_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |-> $past(lo_take));
endmodule

// File: rtl/dml_chan_bank.sv
module dml_chan_bank
    import dml_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  logic [IDX_W-1:0]       wr_idx,
    input  setpt_t                 wr_val,
    output logic [NUM_CH*SP_W-1:0] vals_flat
);
    setpt_t vals [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                vals[c] <= '0;
            end else if (wr_stb && wr_idx == IDX_W'(c)) begin
                vals[c] <= wr_val;
            end
        end
        assign vals_flat[c*SP_W +: SP_W] = vals[c];
    end

    // R8: a strobed value lands in its channel
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (vals[$past(wr_idx)] == $past(wr_val)));

    // R8: with no strobe the bank holds
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(vals_flat));

    // R9: reset zeroes every setpoint
    p_bank_clear_r9: assert property (@(posedge clk)
        rst |=> (vals_flat == '0));
endmodule

// File: rtl/dac_mask_loader.sv
module dac_mask_loader
    import dml_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   wr_stb,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [SP_W-1:0]        wr_val,
    output logic                   done_stb,
    output logic [NUM_CH-1:0]      done_mask,
    output logic [NUM_CH*SP_W-1:0] ch_vals
);
    logic             mask_shift;
    logic             hi_load;
    logic             lo_take;
    logic             last_ch;
    logic [IDX_W-1:0] ch_idx;
    logic [NUM_CH-1:0] mask_q;

    dml_sequencer #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .mask_shift(mask_shift),
        .hi_load   (hi_load),
        .lo_take   (lo_take),
        .last_ch   (last_ch),
        .ch_idx    (ch_idx)
    );

    dml_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .shift_en(mask_shift),
        .in_byte (in_byte),
        .mask_q  (mask_q)
    );

    dml_word_asm #(.NUM_CH(NUM_CH)) u_word (
        .clk     (clk),
        .rst     (rst),
        .hi_load (hi_load),
        .lo_take (lo_take),
        .last_ch (last_ch),
        .ch_sel  (mask_q[ch_idx]),
        .ch_idx  (ch_idx),
        .hi_bits (in_byte[5:0]),
        .lo_bits (in_byte),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .done_stb(done_stb)
    );

    dml_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .vals_flat(ch_vals)
    );

    assign done_mask = mask_q;

    // R6: a strobe only ever names a selected channel
    p_stb_masked_r6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> done_mask[wr_idx]);

    // R6: strobe and done never outlive one cycle for the same channel
    p_stb_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
endmodule

// File: tb/dac_mask_loader_bench.sv
module dac_mask_loader_bench;
    localparam int NCH = 32;
    localparam int SPW = 14;

    typedef struct packed {
        logic [31:0] mask;
        logic [15:0] seed;
        logic        junk;
        logic        gaps;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t TBL [NVEC] = '{
        '{mask: 32'hFFFF_FFFF, seed: 16'h1234, junk: 1'b0, gaps: 1'b0},
        '{mask: 32'h07FF_C000, seed: 16'h0ABC, junk: 1'b1, gaps: 1'b0},
        '{mask: 32'h8000_0001, seed: 16'h3F00, junk: 1'b0, gaps: 1'b1},
        '{mask: 32'h0000_0000, seed: 16'h7777, junk: 1'b1, gaps: 1'b0},
        '{mask: 32'hA5A5_5A5A, seed: 16'h0050, junk: 1'b1, gaps: 1'b1},
        '{mask: 32'h0000_FF00, seed: 16'h2468, junk: 1'b0, gaps: 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             wr_stb;
    logic [4:0]       wr_idx;
    logic [SPW-1:0]   wr_val;
    logic             done_stb;
    logic [NCH-1:0]   done_mask;
    logic [NCH*SPW-1:0] ch_vals;

    int n_chk = 0;
    int n_bad = 0;
    logic [SPW-1:0] model [NCH];

    always #2 clk = ~clk;

    dac_mask_loader #(.NUM_CH(NCH)) u_dac_mask_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_val(wr_val),
        .done_stb(done_stb), .done_mask(done_mask), .ch_vals(ch_vals)
    );

    function automatic logic [SPW-1:0] gen_val(input logic [15:0] seed, input int c);
        logic [15:0] t;
        t = seed + 16'(c) * 16'h0265;
        t = t ^ (16'(c) << 3);
        return t[SPW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [7:0] b, input bit gap);
        if (gap) begin
            in_valid = 1'b0;
            in_byte  = 8'h50;
            step();
        end
        in_valid = 1'b1;
        in_byte  = b;
        step();
        in_valid = 1'b0;
    endtask

    task automatic check_bank(input string req);
        logic [NCH*SPW-1:0] e;
        for (int c = 0; c < NCH; c++) e[c*SPW +: SPW] = model[c];
        chk(ch_vals == e, req, 64'(ch_vals ^ e), 64'h0);
    endtask

    task automatic send_pkt(input vec_t v);
        logic [SPW-1:0] sv;
        put(8'h50, v.gaps);
        for (int k = 3; k >= 0; k--) put(v.mask[k*8 +: 8], v.gaps);
        for (int c = 0; c < NCH; c++) begin
            sv = gen_val(v.seed, c);
            put({(v.junk ? 2'b11 : 2'b00), sv[13:8]}, v.gaps);
            put(sv[7:0], v.gaps);
            // R3 R6: strobe only for selected channels
            chk(wr_stb == v.mask[c], "R6 R3 strobe select", 64'(wr_stb), 64'(v.mask[c]));
            if (v.mask[c]) begin
                // R4 R5: index and assembled value
                chk(wr_idx == 5'(c), "R4 index", 64'(wr_idx), 64'(c));
                chk(wr_val == sv, "R5 value", 64'(wr_val), 64'(sv));
                model[c] = sv;
            end
            chk(done_stb == (c == NCH-1), "R7 done timing", 64'(done_stb), 64'(c == NCH-1));
        end
        // R7 R2: captured mask on the done pulse
        chk(done_mask == v.mask, "R7 R2 done mask", 64'(done_mask), 64'(v.mask));
        step();
        chk(!wr_stb && !done_stb, "R6 R7 single pulse", 64'({wr_stb, done_stb}), 64'h0);
        // R8: selected channels updated, others kept
        check_bank("R8 bank contents");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = '0;
        step(); step();
        rst = 1'b0;
        // R9: reset state
        chk(!wr_stb && !done_stb && ch_vals == '0 && done_mask == '0, "R9 reset state",
            64'(ch_vals), 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            // R1: junk in idle is dropped before each packet
            put(8'h00, 1'b0);
            put(8'hFF, 1'b0);
            put(8'h51, 1'b0);
            chk(!wr_stb && !done_stb, "R1 idle junk", 64'({wr_stb, done_stb}), 64'h0);
            check_bank("R1 junk keeps bank");
            // R10 exercised by entries with gaps; R5 by junk high bits
            send_pkt(TBL[i]);
        end

        // R9: reset in the middle of a packet
        put(8'h50, 1'b0);
        put(8'hFF, 1'b0);
        put(8'hFF, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) model[c] = '0;
        chk(ch_vals == '0 && done_mask == '0, "R9 mid-packet reset", 64'(ch_vals), 64'h0);
        // R9 R1: parser idle after reset, a full packet lands correctly
        send_pkt('{mask: 32'h07FF_C000, seed: 16'h5A5A, junk: 1'b1, gaps: 1'b0});

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule